// File: doc/BRIEF.md
# Coherent Attribute Table Mailbox Responder

This block serves table-read requests that arrive in a data-object-exchange style mailbox and answers each one with a single entry of a fixed device attribute table. The requester presents one request per strobe. The strobe carries the object length in dwords and the entry handle it wants. If the request is long enough, the responder streams a response one dword per pop. The response begins with a three-dword header: an identity dword, a length dword, and a dword with the response code, the table type and the handle of the entry that follows. The entry payload comes after the header. A running counter adds up the response lengths placed in the read mailbox.

The table describes one non-volatile memory range and has six entries in a fixed order. Entry 0 is the range entry. Entries 1 to 4 are performance entries: read latency, write latency, read bandwidth and write bandwidth. Entry 5 is the memory-type entry. All entries use affinity handle 0. The controller has four states. S_IDLE waits for a request. S_DROP spends one cycle discarding a short request. S_HDR emits the three header dwords. S_BODY emits the payload. The transitions are:

- accept: S_IDLE to S_HDR, on a request of sufficient length.
- reject: S_IDLE to S_DROP, on a short request.
- recover: S_DROP to S_IDLE.
- header_done: S_HDR to S_BODY, on the pop of header dword 2.
- finish: S_BODY to S_IDLE, on the pop of the last dword.

Top module: `cdat_mbox_resp`

## Requirements
- R1: A request whose length field is below 3 dwords produces no response and leaves `mbox_len` unchanged. `busy` is high for exactly one cycle after such a request and then returns low.
- R2: Response dword 0 is {8'h00, object type 8'h02 in bits 23:16, vendor ID 16'h1E98 in bits 15:0}. Response dword 1 holds the response length in dwords, which is ceil((12 + entry bytes) / 4).
- R3: Response dword 2 is {next handle in bits 31:16, table type 8'h00 in bits 15:8, response code 8'h00 in bits 7:0}. The next handle is the served entry index plus one.
- R4: When the last entry (index 5) is served, the next handle is 16'hFFFF. A handle of 6 or more serves entry 5.
- R5: The payload starts at response dword 3. An entry whose byte count is not a multiple of 4 is padded with zero bytes up to the last dword.
- R6: Every entry starts with the header dword {byte count in bits 31:16, 8'h00, kind in bits 7:0}. The kinds are range = 0, performance = 1 and memory type = 2.
  - The range entry is 24 bytes. Dword 1 holds flags 8'h01 (non-volatile) in bits 15:8 and the handle in bits 7:0. Dwords 2 and 3 hold the 64-bit base, which is 0. Dwords 4 and 5 hold the 64-bit length, which equals MEM_BYTES.
  - The memory-type entry is 24 bytes. Dword 1 holds attribute 2 in bits 15:8. Dwords 2 and 3 hold the offset, which is 0. Dwords 4 and 5 hold the length, which is MEM_BYTES.
- R7: Each performance entry is 18 bytes.
  - Dword 1 holds the data type in bits 23:16: read latency = 0, write latency = 1, read bandwidth = 2, write bandwidth = 3.
  - Dwords 2 and 3 hold the 64-bit base unit: 10000 for latency, 1000 for bandwidth.
  - Bits 15:0 of dword 4 hold the value: 15, 25, 16 and 16 in that order.
- R8: `busy` is high from the cycle after an accepted request until the last dword is popped. Requests presented while `busy` is high are ignored. `rsp_data` holds while `rsp_valid` is high and `rsp_pop` is low. `rsp_last` marks the final dword.
- R9: `mbox_len` grows by the response length one cycle after the first response dword appears.
- R10: After reset, `busy`, `rsp_valid` and `rsp_last` are 0 and `mbox_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled only while idle |
| req_len | input | LEN_W | Request object length in dwords |
| req_handle | input | 16 | Requested entry handle |
| busy | output | 1 | Responder occupied; new requests are ignored |
| rsp_pop | input | 1 | Consumer takes the current response dword |
| rsp_valid | output | 1 | A response dword is available |
| rsp_data | output | 32 | Current response dword |
| rsp_last | output | 1 | Current dword is the last of the response |
| mbox_len | output | CNT_W | Running total of response dwords placed |

## Verification
The bench goes after the handle chain at the table's end. A design that chained past the last entry would report handle 6 instead of 16'hFFFF, and one that indexed past the table would return zero payloads for handle 9. The 18-byte performance entries check the length rounding: a design that rounded down would report 7 dwords and cut off the value dword. The bench also sends requests of length 2 and 0, and requests while the responder is busy; a design that accepted any of these would start an extra response or bump `mbox_len`. Pops are stalled irregularly to catch data that moves without a pop, and a new request directly after a `rsp_last` pop checks that no idle cycle is lost or gained.

// File: rtl/cdat_mbox_pkg.sv
package cdat_mbox_pkg;
    localparam int N_ENT      = 6;
    localparam int ENT_W      = 3;
    localparam int HDR_DW     = 3;
    localparam int REQ_DW     = 3;
    localparam int WIDX_W     = 5;
    localparam int PAY_W      = 3;
    localparam logic [15:0] EOT_HANDLE = 16'hFFFF;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_DROP = 2'd1,
        S_HDR  = 2'd2,
        S_BODY = 2'd3
    } rsp_state_t;

    typedef enum logic [7:0] {
        K_RANGE = 8'd0,
        K_PERF  = 8'd1,
        K_MTYPE = 8'd2
    } ent_kind_t;
endpackage

// File: rtl/cdat_entry_rom.sv
module cdat_entry_rom
    import cdat_mbox_pkg::*;
#(
    parameter logic [63:0] MEM_BYTES = 64'h0000_0002_4000_0000,
    parameter logic [63:0] LAT_UNIT  = 64'd10000,
    parameter logic [63:0] BW_UNIT   = 64'd1000,
    parameter logic [15:0] RD_LAT    = 16'd15,
    parameter logic [15:0] WR_LAT    = 16'd25,
    parameter logic [15:0] RD_BW     = 16'd16,
    parameter logic [15:0] WR_BW     = 16'd16
) (
    input  logic [ENT_W-1:0] ent,
    input  logic [PAY_W-1:0] word,
    output logic [31:0]      data,
    output logic [15:0]      nbytes
);
    localparam logic [15:0] BIG_BYTES  = 16'd24;
    localparam logic [15:0] PERF_BYTES = 16'd18;
    localparam logic [7:0]  NV_FLAG    = 8'h01;
    localparam logic [7:0]  MTYPE_ATTR = 8'd2;

    logic [63:0] unit_tab [4];
    logic [15:0] val_tab  [4];
    logic [1:0]  pidx;

    for (genvar g = 0; g < 4; g++) begin : g_perf
        assign unit_tab[g] = (g < 2) ? LAT_UNIT : BW_UNIT;
        if (g == 0)      begin : g_v0 assign val_tab[g] = RD_LAT; end
        else if (g == 1) begin : g_v1 assign val_tab[g] = WR_LAT; end
        else if (g == 2) begin : g_v2 assign val_tab[g] = RD_BW;  end
        else             begin : g_v3 assign val_tab[g] = WR_BW;  end
    end

    assign pidx = 2'(ent - ENT_W'(1));

    always_comb begin
        data   = '0;
        nbytes = '0;
        if (ent == '0) begin
            nbytes = BIG_BYTES;
            unique case (word)
                3'd0: data = {BIG_BYTES, 8'h00, K_RANGE};
                3'd1: data = {16'h0000, NV_FLAG, 8'h00};
                3'd4: data = MEM_BYTES[31:0];
                3'd5: data = MEM_BYTES[63:32];
                default: data = '0;
            endcase
        end else if (ent <= ENT_W'(4)) begin
            nbytes = PERF_BYTES;
            unique case (word)
                3'd0: data = {PERF_BYTES, 8'h00, K_PERF};
                3'd1: data = {8'h00, 6'd0, pidx, 8'h00, 8'h00};
                3'd2: data = unit_tab[pidx][31:0];
                3'd3: data = unit_tab[pidx][63:32];
                3'd4: data = {16'h0000, val_tab[pidx]};
                default: data = '0;
            endcase
        end else begin
            nbytes = BIG_BYTES;
            unique case (word)
                3'd0: data = {BIG_BYTES, 8'h00, K_MTYPE};
                3'd1: data = {16'h0000, MTYPE_ATTR, 8'h00};
                3'd4: data = MEM_BYTES[31:0];
                3'd5: data = MEM_BYTES[63:32];
                default: data = '0;
            endcase
        end
    end
endmodule

// File: rtl/cdat_rsp_hdr.sv
module cdat_rsp_hdr
    import cdat_mbox_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1E98,
    parameter logic [7:0]  OBJ_TYPE  = 8'h02,
    parameter logic [7:0]  RSP_CODE  = 8'h00,
    parameter logic [7:0]  TBL_TYPE  = 8'h00
) (
    input  logic [ENT_W-1:0] ent,
    input  logic [15:0]      nbytes,
    input  logic [1:0]       word,
    output logic [31:0]      data,
    output logic [7:0]       rsp_len
);
    localparam logic [15:0] HDR_BYTES = 16'(HDR_DW * 4);

    logic [15:0] total_bytes;
    logic [15:0] next_handle;

    assign total_bytes = HDR_BYTES + nbytes + 16'd3;
    assign rsp_len     = total_bytes[9:2];
    assign next_handle = (ent == ENT_W'(N_ENT - 1)) ? EOT_HANDLE
                                                    : 16'(ent) + 16'd1;

    always_comb begin
        unique case (word)
            2'd0:    data = {8'h00, OBJ_TYPE, VENDOR_ID};
            2'd1:    data = {24'h0, rsp_len};
            default: data = {next_handle, TBL_TYPE, RSP_CODE};
        endcase
    end
endmodule

// File: rtl/cdat_rsp_ctrl.sv
module cdat_rsp_ctrl
    import cdat_mbox_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [15:0]       req_handle,
    input  logic              rsp_pop,
    input  logic [7:0]        rsp_len,
    output logic [ENT_W-1:0]  ent_q,
    output logic [WIDX_W-1:0] widx_q,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_last,
    output logic [CNT_W-1:0]  mbox_len
);
    rsp_state_t        state_q, state_d;
    logic              fresh_q;
    logic              accept;
    logic              short_req;
    logic              at_end;
    logic [ENT_W-1:0]  ent_in;

    assign short_req = req_len < LEN_W'(REQ_DW);
    assign accept    = (state_q == S_IDLE) && req_valid && !short_req;
    assign ent_in    = (req_handle >= 16'(N_ENT)) ? ENT_W'(N_ENT - 1)
                                                  : req_handle[ENT_W-1:0];
    assign at_end    = widx_q == WIDX_W'(rsp_len - 8'd1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_valid) state_d = short_req ? S_DROP : S_HDR;
            S_DROP: state_d = S_IDLE;
            S_HDR:  if (rsp_pop && widx_q == WIDX_W'(HDR_DW - 1)) state_d = S_BODY;
            S_BODY: if (rsp_pop && at_end) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            widx_q   <= '0;
            ent_q    <= '0;
            fresh_q  <= 1'b0;
            mbox_len <= '0;
        end else begin
            fresh_q <= accept;
            if (accept) begin
                widx_q <= '0;
                ent_q  <= ent_in;
            end else if (rsp_valid && rsp_pop) begin
                widx_q <= widx_q + WIDX_W'(1);
            end
            if (fresh_q) mbox_len <= mbox_len + CNT_W'(rsp_len);
        end
    end

    assign busy      = state_q != S_IDLE;
    assign rsp_valid = (state_q == S_HDR) || (state_q == S_BODY);
    assign rsp_last  = (state_q == S_BODY) && at_end;
endmodule

// File: rtl/cdat_mbox_resp.sv
module cdat_mbox_resp
    import cdat_mbox_pkg::*;
#(
    parameter int          LEN_W     = 10,
    parameter int          CNT_W     = 16,
    parameter logic [63:0] MEM_BYTES = 64'h0000_0002_4000_0000,
    parameter logic [15:0] VENDOR_ID = 16'h1E98
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LEN_W-1:0] req_len,
    input  logic [15:0]      req_handle,
    output logic             busy,
    input  logic             rsp_pop,
    output logic             rsp_valid,
    output logic [31:0]      rsp_data,
    output logic             rsp_last,
    output logic [CNT_W-1:0] mbox_len
);
    logic [ENT_W-1:0]  ent_q;
    logic [WIDX_W-1:0] widx_q;
    logic [7:0]        rsp_len;
    logic [15:0]       nbytes;
    logic [31:0]       hdr_data;
    logic [31:0]       rom_data;
    logic [WIDX_W-1:0] pay_idx;

    assign pay_idx = widx_q - WIDX_W'(HDR_DW);

    cdat_rsp_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_len(req_len), .req_handle(req_handle),
        .rsp_pop(rsp_pop), .rsp_len(rsp_len),
        .ent_q(ent_q), .widx_q(widx_q),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_last(rsp_last),
        .mbox_len(mbox_len)
    );

    cdat_entry_rom #(.MEM_BYTES(MEM_BYTES)) u_rom (
        .ent(ent_q), .word(pay_idx[PAY_W-1:0]),
        .data(rom_data), .nbytes(nbytes)
    );

    cdat_rsp_hdr #(.VENDOR_ID(VENDOR_ID)) u_hdr (
        .ent(ent_q), .nbytes(nbytes), .word(widx_q[1:0]),
        .data(hdr_data), .rsp_len(rsp_len)
    );

    assign rsp_data = !rsp_valid ? 32'h0 :
                      (widx_q < WIDX_W'(HDR_DW)) ? hdr_data : rom_data;
endmodule

module cdat_mbox_resp_chk #(
    parameter int          LEN_W     = 10,
    parameter int          CNT_W     = 16,
    parameter logic [15:0] VENDOR_ID = 16'h1E98
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic             rsp_pop,
    input logic             rsp_valid,
    input logic [31:0]      rsp_data,
    input logic             rsp_last,
    input logic [CNT_W-1:0] mbox_len
);
    // R1: a short request never opens a response
    p_drop_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_len < LEN_W'(3)) |=> !rsp_valid);

    // R2: first dword of every response carries the vendor identity
    p_first_vendor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> rsp_data[15:0] == VENDOR_ID);

    // R8: a stalled dword stays put
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_pop) |=> (rsp_valid && $stable(rsp_data)));

    // R8: no data offered while idle
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rsp_valid && !rsp_last));

    // R9: counter moves one cycle after a response opens
    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |=> mbox_len != $past(mbox_len));

    // R9: counter is quiet while a response streams past its first cycle
    p_count_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |=> $stable(mbox_len));
endmodule

bind cdat_mbox_resp cdat_mbox_resp_chk #(
    .LEN_W(LEN_W), .CNT_W(CNT_W), .VENDOR_ID(VENDOR_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .busy(busy), .rsp_pop(rsp_pop), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_last(rsp_last), .mbox_len(mbox_len)
);

// File: tb/cdat_mbox_resp_tb.sv
module cdat_mbox_resp_tb;
    localparam int          LEN_W = 10;
    localparam int          CNT_W = 16;
    localparam logic [63:0] MEM   = 64'h0000_0002_4000_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [LEN_W-1:0] req_len = '0;
    logic [15:0]      req_handle = '0;
    logic             busy, rsp_valid, rsp_last;
    logic             rsp_pop = 1'b0;
    logic [31:0]      rsp_data;
    logic [CNT_W-1:0] mbox_len;

    int  vectors = 0;
    int  fails = 0;
    bit  done = 0;
    int  pop_mode = 0;
    int  pop_cnt = 0;

    always #4 clk = ~clk;

    cdat_mbox_resp u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_handle(req_handle), .busy(busy), .rsp_pop(rsp_pop),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last),
        .mbox_len(mbox_len)
    );

    // reference model state
    logic [31:0] m_q[$];
    int          m_total = 0;
    int          m_ent = 0;
    bit          m_drop = 0;
    bit          m_dropped = 0;
    int          m_add = 0;
    int          m_mbox = 0;

    function automatic void push64(ref byte unsigned b[$], input logic [63:0] v);
        for (int i = 0; i < 8; i++) b.push_back(v[8*i +: 8]);
    endfunction

    task automatic build(input int h);
        byte unsigned b[$];
        int ent, nxt, n;
        ent = (h >= 6) ? 5 : h;
        nxt = (ent < 5) ? ent + 1 : 16'hFFFF;
        if (ent == 0 || ent == 5) begin
            b.push_back((ent == 0) ? 8'd0 : 8'd2); b.push_back(8'd0);
            b.push_back(8'd24); b.push_back(8'd0);
            b.push_back(8'd0);  b.push_back((ent == 0) ? 8'h01 : 8'h02);
            b.push_back(8'd0);  b.push_back(8'd0);
            push64(b, 64'd0);
            push64(b, MEM);
        end else begin
            b.push_back(8'd1); b.push_back(8'd0);
            b.push_back(8'd18); b.push_back(8'd0);
            b.push_back(8'd0); b.push_back(8'd0);
            b.push_back(8'(ent - 1)); b.push_back(8'd0);
            push64(b, (ent <= 2) ? 64'd10000 : 64'd1000);
            case (ent)
                1: b.push_back(8'd15);
                2: b.push_back(8'd25);
                default: b.push_back(8'd16);
            endcase
            b.push_back(8'd0);
        end
        n = (12 + b.size() + 3) / 4;
        while (b.size() % 4 != 0) b.push_back(8'd0);
        m_q.delete();
        m_q.push_back({8'h00, 8'h02, 16'h1E98});
        m_q.push_back(32'(n));
        m_q.push_back({16'(nxt), 8'h00, 8'h00});
        for (int i = 0; i < b.size(); i += 4)
            m_q.push_back({b[i+3], b[i+2], b[i+1], b[i]});
        m_total = m_q.size();
        m_ent = ent;
        m_add = n;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete(); m_drop = 0; m_add = 0; m_mbox = 0; m_dropped = 0;
        end else begin
            if (m_add != 0 && m_q.size() == m_total && m_total != 0 && !m_drop) begin
                m_mbox += m_add;
                m_add = 0;
            end
            if (m_q.size() > 0) begin
                if (rsp_pop) void'(m_q.pop_front());
            end else if (m_drop) begin
                m_drop = 0;
            end else if (req_valid) begin
                if (req_len < 3) begin
                    m_drop = 1; m_dropped = 1;
                end else begin
                    m_dropped = 0;
                    build(int'(req_handle));
                    m_add = -m_add;
                end
            end
            if (m_add < 0) m_add = -m_add;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev;
            int p;
            string tg;
            ev = m_q.size() > 0;
            p  = m_total - m_q.size();
            check(busy == (ev || m_drop), m_drop ? "R1" : "R8", "busy",
                  64'(busy), 64'(ev || m_drop));
            check(rsp_valid == ev, m_dropped ? "R1" : "R8", "rsp_valid",
                  64'(rsp_valid), 64'(ev));
            check(rsp_last == (m_q.size() == 1), "R8", "rsp_last",
                  64'(rsp_last), 64'(m_q.size() == 1));
            check(int'(mbox_len) == m_mbox, "R9", "mbox_len",
                  64'(mbox_len), 64'(m_mbox));
            if (ev) begin
                if (p < 2) tg = "R2";
                else if (p == 2) tg = (m_ent == 5) ? "R4" : "R3";
                else if (m_ent == 0 || m_ent == 5) tg = "R6";
                else if (m_q.size() == 1) tg = "R5";
                else tg = "R7";
                check(rsp_data == m_q[0], tg, "rsp_data", 64'(rsp_data), 64'(m_q[0]));
            end
        end
    end

    always @(negedge clk) begin
        pop_cnt++;
        case (pop_mode)
            0: rsp_pop = 1'b1;
            1: rsp_pop = (pop_cnt % 3) == 0;
            default: rsp_pop = (pop_cnt % 5) > 1;
        endcase
    end

    task automatic send(input int len, input int h);
        @(negedge clk);
        req_valid = 1'b1; req_len = LEN_W'(len); req_handle = 16'(h);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset values
        check(!busy && !rsp_valid && !rsp_last && mbox_len == '0, "R10", "reset",
              {busy, rsp_valid, rsp_last, 13'd0, mbox_len}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int h = 0; h < 6; h++) begin   // R3 R6 R7 chain through table
            send(3, h);
            wait_idle();
        end
        pop_mode = 1;                        // R8 stalls and busy ignore
        send(4, 2);
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_len = LEN_W'(3); req_handle = 16'd0;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        send(2, 1);                          // R1 short request
        wait_idle();
        send(0, 3);
        wait_idle();
        pop_mode = 2;
        send(3, 9);                          // R4 out-of-range handle
        wait_idle();
        send(3, 16'hFFFF);
        wait_idle();
        send(7, 5);                          // R4 last entry
        wait_idle();
        pop_mode = 0;                        // back-to-back after rsp_last
        send(3, 4);
        @(negedge clk);
        while (!rsp_last) @(negedge clk);
        req_valid = 1'b1; req_len = LEN_W'(3); req_handle = 16'd1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end
endmodule